// File: doc/BRIEF.md
# Two-Level Interrupt Entry Sequencer

This block handles exception entry and exception return for a simple in-order core that has two interrupt lines: a fast line and a normal line. The lines are level-sensitive and are only looked at on instruction boundaries. A boundary is either a retire strobe from the pipeline or an exception-return strobe. At each boundary the block picks the highest-priority line whose mask bit is clear. It then saves the status word and the resume address into a register set kept for that level, raises the mask bits for the new level, and sends out a one-cycle redirect pulse with a vector select.

An exception return restores the saved status of the level that is running. That restore is itself a boundary, and it is judged against the restored masks. A request that is still pending is therefore taken again before the interrupted instruction runs, and the new handler saves the same resume address. Each level has its own saved registers, so a fast interrupt that preempts a normal handler leaves the normal handler's saved state intact. The block never clears a request line; the handler has to clear the device request.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is at thread level (activeLevel 0). Both masks are clear, resumeAddr is 0 and no redirect pulse is issued.
- R2: A request is taken only at a boundary, meaning a retire strobe or an accepted return strobe. A pending unmasked line with neither strobe gives no redirect.
- R3: If both lines are pending and unmasked at the same boundary, the fast line is taken (takeVec 1).
- R4: Fast entry gives a redirect with takeVec 1 in the next cycle. It sets activeLevel to 2 and sets both fastMask and normMask.
- R5: Normal entry gives a redirect with takeVec 0 in the next cycle. It sets activeLevel to 1 and sets normMask, and fastMask keeps its previous value.
- R6: takeValid is high only in the cycle after a boundary that takes a request. It is low when the next boundary takes nothing.
- R7: On an entry at a retire boundary, the saved resume address is retireNextPc of that cycle. resumeAddr shows it while that level is active.
- R8: A line whose mask bit is set is not taken at a boundary. The normal line is ignored in the normal handler, and both lines are ignored in the fast handler.
- R9: A return strobe at level 1 or 2 restores the status saved at entry to that level: level, fastMask and normMask.
- R10: A fast entry from the normal handler does not change the normal level's saved status or address. After the fast return, activeLevel is 1 and resumeAddr is the normal handler's saved address.
- R11: When a line is still pending and unmasked under the status restored by a return, it is taken at that return boundary. The new entry saves the returning level's resume address.
- R12: A return strobe at thread level does nothing, and any retire strobe in the same cycle is ignored. Whenever retStrobe is high, retireValid is disregarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | Instruction boundary from the retire stage |
| retireNextPc | input | ADDR_W | Address of the next instruction that has not executed |
| retStrobe | input | 1 | Exception-return instruction at this boundary |
| fastReq | input | 1 | Fast interrupt line, level-sensitive |
| normReq | input | 1 | Normal interrupt line, level-sensitive |
| takeValid | output | 1 | One-cycle redirect request |
| takeVec | output | 1 | Vector select: 0 normal, 1 fast |
| resumeAddr | output | ADDR_W | Saved return address of the active level (0 at thread level) |
| fastMask | output | 1 | Live fast-interrupt mask |
| normMask | output | 1 | Live normal-interrupt mask |
| activeLevel | output | 2 | 0 thread, 1 normal handler, 2 fast handler |

## Verification
The bench builds the block with the default 32-bit address width. Each entry point in the bench is given its own address, so a single resumeAddr compare shows which saved bank is being shown after a preemption and its return. The same width lets a re-entry at a return boundary be told apart from a fresh entry at a retire boundary, because the two save different addresses.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    LVL_THREAD = 2'd0,
    LVL_NORM   = 2'd1,
    LVL_FAST   = 2'd2
  } level_e;

  typedef struct packed {
    level_e level;
    logic   fastMask;
    logic   normMask;
  } status_t;

  typedef struct packed {
    logic doReturn;
    logic takeFast;
    logic takeNorm;
  } strobes_t;

  localparam int NUM_BANKS = 2;
  localparam int BANK_NORM = 0;
  localparam int BANK_FAST = 1;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic     retireValid,
  input  logic     retStrobe,
  input  logic     fastReq,
  input  logic     normReq,
  input  level_e   curLevel,
  input  logic     curFastMask,
  input  logic     curNormMask,
  input  logic     restFastMask,
  input  logic     restNormMask,
  output strobes_t strobes
);
  logic doReturn;
  logic boundary;
  logic effFast;
  logic effNorm;
  logic fastOk;

  always_comb begin
    // a return at thread level is dropped; retire is ignored during a return
    doReturn = retStrobe && (curLevel != LVL_THREAD);
    boundary = doReturn || (retireValid && !retStrobe);
    effFast  = doReturn ? restFastMask : curFastMask;
    effNorm  = doReturn ? restNormMask : curNormMask;
    fastOk   = boundary && fastReq && !effFast;
    strobes.doReturn = doReturn;
    strobes.takeFast = fastOk;
    strobes.takeNorm = boundary && normReq && !effNorm && !fastOk;
  end
endmodule

// File: rtl/irq_seq_dpath.sv
module irq_seq_dpath
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [ADDR_W-1:0] retireNextPc,
  output status_t           curStatus,
  output status_t           restoredStatus,
  output logic              takeValid,
  output logic              takeVec,
  output logic [ADDR_W-1:0] resumeAddr
);
  status_t           statusQ;
  status_t           savedStatus [NUM_BANKS];
  logic [ADDR_W-1:0] savedAddr   [NUM_BANKS];
  logic [NUM_BANKS-1:0] bankWr;
  logic              curBank;
  status_t           effStatus;
  logic [ADDR_W-1:0] entryAddr;

  always_comb begin
    curBank        = (statusQ.level == LVL_FAST);
    restoredStatus = savedStatus[curBank];
    effStatus      = strobes.doReturn ? restoredStatus : statusQ;
    entryAddr      = strobes.doReturn ? savedAddr[curBank] : retireNextPc;
    bankWr[BANK_NORM] = strobes.takeNorm;
    bankWr[BANK_FAST] = strobes.takeFast;
    curStatus      = statusQ;
    resumeAddr     = (statusQ.level == LVL_THREAD) ? '0 : savedAddr[curBank];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        savedStatus[b] <= '{LVL_THREAD, 1'b0, 1'b0};
        savedAddr[b]   <= '0;
      end else if (bankWr[b]) begin
        savedStatus[b] <= effStatus;
        savedAddr[b]   <= entryAddr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ   <= '{LVL_THREAD, 1'b0, 1'b0};
      takeValid <= 1'b0;
      takeVec   <= 1'b0;
    end else begin
      takeValid <= strobes.takeFast || strobes.takeNorm;
      takeVec   <= strobes.takeFast;
      if (strobes.takeFast)
        statusQ <= '{LVL_FAST, 1'b1, 1'b1};
      else if (strobes.takeNorm)
        statusQ <= '{LVL_NORM, effStatus.fastMask, 1'b1};
      else if (strobes.doReturn)
        statusQ <= restoredStatus;
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireValid,
  input  logic [ADDR_W-1:0] retireNextPc,
  input  logic              retStrobe,
  input  logic              fastReq,
  input  logic              normReq,
  output logic              takeValid,
  output logic              takeVec,
  output logic [ADDR_W-1:0] resumeAddr,
  output logic              fastMask,
  output logic              normMask,
  output logic [1:0]        activeLevel
);
  strobes_t strobes;
  status_t  curStatus;
  status_t  restoredStatus;

  irq_seq_ctrl ctrl_i (
    .retireValid (retireValid),
    .retStrobe   (retStrobe),
    .fastReq     (fastReq),
    .normReq     (normReq),
    .curLevel    (curStatus.level),
    .curFastMask (curStatus.fastMask),
    .curNormMask (curStatus.normMask),
    .restFastMask(restoredStatus.fastMask),
    .restNormMask(restoredStatus.normMask),
    .strobes     (strobes)
  );

  irq_seq_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .retireNextPc  (retireNextPc),
    .curStatus     (curStatus),
    .restoredStatus(restoredStatus),
    .takeValid     (takeValid),
    .takeVec       (takeVec),
    .resumeAddr    (resumeAddr)
  );

  assign fastMask    = curStatus.fastMask;
  assign normMask    = curStatus.normMask;
  assign activeLevel = curStatus.level;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       retireValid,
  input logic       retStrobe,
  input logic       fastReq,
  input logic       takeValid,
  input logic       takeVec,
  input logic       fastMask,
  input logic       normMask,
  input logic [1:0] activeLevel
);
  AST_TAKE_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |-> $past(retireValid || retStrobe)); // R2

  AST_FAST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid && !takeVec) |-> !$past(fastReq)); // R3

  AST_FAST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid && takeVec) |-> (fastMask && normMask && activeLevel == 2'd2)); // R4

  AST_NORM_ENTRY_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid && !takeVec) |-> (normMask && activeLevel == 2'd1)); // R5

  AST_FAST_LEVEL_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (activeLevel == 2'd2) |-> (fastMask && normMask)); // R8

  AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    activeLevel != 2'd3); // R9
endmodule

bind irq_entry_seq irq_entry_seq_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .retireValid(retireValid),
  .retStrobe  (retStrobe),
  .fastReq    (fastReq),
  .takeValid  (takeValid),
  .takeVec    (takeVec),
  .fastMask   (fastMask),
  .normMask   (normMask),
  .activeLevel(activeLevel)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              retireValid;
  logic [ADDR_W-1:0] retireNextPc;
  logic              retStrobe;
  logic              fastReq;
  logic              normReq;
  logic              takeValid;
  logic              takeVec;
  logic [ADDR_W-1:0] resumeAddr;
  logic              fastMask;
  logic              normMask;
  logic [1:0]        activeLevel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_entry_seq #(.ADDR_W(ADDR_W)) dut_i (.*);

  typedef struct packed {
    logic        retire;
    logic        ret;
    logic        fReq;
    logic        nReq;
    logic [31:0] pc;
    logic        eTake;
    logic        eVec;
    logic [1:0]  eLvl;
    logic        eF;
    logic        eN;
    logic [31:0] eAddr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // rt  ret fq   nq   pc            take vec  lvl    F    N    addr          req
    '{1'b0,1'b0,1'b0,1'b1,32'h0000_0100,1'b0,1'b0,2'd0,1'b0,1'b0,32'h0000_0000,4'd2},  // R2 no boundary
    '{1'b1,1'b0,1'b0,1'b1,32'h0000_0104,1'b1,1'b0,2'd1,1'b0,1'b1,32'h0000_0104,4'd5},  // R5 R7
    '{1'b1,1'b0,1'b0,1'b1,32'h0000_0200,1'b0,1'b0,2'd1,1'b0,1'b1,32'h0000_0104,4'd6},  // R6 R8 masked normal
    '{1'b1,1'b0,1'b1,1'b1,32'h0000_0208,1'b1,1'b1,2'd2,1'b1,1'b1,32'h0000_0208,4'd4},  // R4 preempt
    '{1'b1,1'b0,1'b1,1'b1,32'h0000_0300,1'b0,1'b0,2'd2,1'b1,1'b1,32'h0000_0208,4'd8},  // R8 fast masked
    '{1'b0,1'b1,1'b0,1'b0,32'h0000_0000,1'b0,1'b0,2'd1,1'b0,1'b1,32'h0000_0104,4'd10}, // R10 normal state kept
    '{1'b0,1'b1,1'b0,1'b0,32'h0000_0000,1'b0,1'b0,2'd0,1'b0,1'b0,32'h0000_0000,4'd9},  // R9 back to thread
    '{1'b1,1'b0,1'b1,1'b1,32'h0000_0400,1'b1,1'b1,2'd2,1'b1,1'b1,32'h0000_0400,4'd3},  // R3 both pending
    '{1'b0,1'b1,1'b0,1'b1,32'h0000_0000,1'b1,1'b0,2'd1,1'b0,1'b1,32'h0000_0400,4'd11}, // R11 normal at fast return
    '{1'b1,1'b0,1'b0,1'b1,32'h0000_0500,1'b0,1'b0,2'd1,1'b0,1'b1,32'h0000_0400,4'd6},  // R6 pulse ends
    '{1'b0,1'b1,1'b0,1'b0,32'h0000_0000,1'b0,1'b0,2'd0,1'b0,1'b0,32'h0000_0000,4'd9},  // R9
    '{1'b1,1'b1,1'b1,1'b1,32'h0000_0700,1'b0,1'b0,2'd0,1'b0,1'b0,32'h0000_0000,4'd12}, // R12 thread return ignored
    '{1'b1,1'b0,1'b1,1'b0,32'h0000_0600,1'b1,1'b1,2'd2,1'b1,1'b1,32'h0000_0600,4'd7},  // R7 fast entry address
    '{1'b0,1'b1,1'b1,1'b0,32'h0000_0000,1'b1,1'b1,2'd2,1'b1,1'b1,32'h0000_0600,4'd11}, // R11 still pending, retaken
    '{1'b0,1'b1,1'b0,1'b0,32'h0000_0000,1'b0,1'b0,2'd0,1'b0,1'b0,32'h0000_0000,4'd9}   // R9
  };

  task automatic checkOut(input int req, input int step, input logic eTake, input logic eVec,
                          input logic [1:0] eLvl, input logic eF, input logic eN,
                          input logic [31:0] eAddr);
    checks++;
    if (takeValid !== eTake || (eTake && takeVec !== eVec) || activeLevel !== eLvl ||
        fastMask !== eF || normMask !== eN || resumeAddr !== eAddr) begin
      fails++;
      $display("FAIL R%0d step %0d: got take=%b vec=%b lvl=%0d f=%b n=%b addr=%h expected take=%b vec=%b lvl=%0d f=%b n=%b addr=%h",
               req, step, takeValid, takeVec, activeLevel, fastMask, normMask, resumeAddr,
               eTake, eVec, eLvl, eF, eN, eAddr);
    end
  endtask

  task automatic drive(input logic rt, input logic rs, input logic fq, input logic nq,
                       input logic [31:0] pc);
    retireValid = rt; retStrobe = rs; fastReq = fq; normReq = nq; retireNextPc = pc;
  endtask

  initial begin
    rstN = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    checkOut(1, 0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].retire, VECS[i].ret, VECS[i].fReq, VECS[i].nReq, VECS[i].pc);
      @(negedge clk);
      checkOut(int'(VECS[i].req), i + 1, VECS[i].eTake, VECS[i].eVec, VECS[i].eLvl,
               VECS[i].eF, VECS[i].eN, VECS[i].eAddr);
    end

    // R1: reset in the middle of a handler returns to the reset state
    drive(1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_0800);
    @(negedge clk);
    checkOut(5, 100, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 32'h0000_0800);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    checkOut(1, 101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);

    // R2: held request with no strobe for several cycles is never taken
    drive(1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0900);
    repeat (3) @(negedge clk);
    checkOut(2, 102, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule